// File: doc/BRIEF.md
# Selectable-Source Integer Clock Divider Bank

This block holds five integer clock dividers, named A to E, that share one system clock. Every clock source is modelled as a one-cycle enable pulse ("tick") in the system clock domain, together with a level that says whether that source is running. Each divider has one control word. The word picks a source, a divide ratio and a disable bit. The divider turns the selected tick stream into a slower tick stream: one output tick for every (D+1) source ticks.

Each divider accepts only the sources on its own allowed list. A write that names any other source is dropped in full and raises that divider's error flag. A divider reports itself running only when it is not disabled and the source it selects reports running. For dividers B to E this source can be divider A, so the status follows the whole chain back to the external input.

Top module: `clkdiv_bank`

## Requirements
- R1: After reset every divider reads back 0x0100_0001: disabled, source code 1, divide value 0. All error flags are low, all status outputs are low and no output ticks appear.
- R2: The control word of divider n (A=0 … E=4) sits at byte address 0x48 + 4·n. Reads return bit 0 = disable, the divide value starting at bit 2 and the source code in bits 28:24, with every other bit zero. Writes to any other address change nothing, and reads of any other address return zero.
- R3: While bit 0 of a divider's word is 1, that divider emits no output ticks.
- R4: With divide value D, an enabled divider emits one output tick for every D+1 ticks of its selected source. The tick appears in the cycle after the completing source tick, so D = 0 passes every source tick one cycle later. D is 2 bits (bits 3:2) for A, 4 bits (bits 5:2) for B, C and D, and 8 bits (bits 9:2) for E. Wider write data is cut to that width.
- R5: Source codes: 0 slow 32 kHz oscillator, 1 internal RC oscillator, 2 Ethernet receive clock, 3 Ethernet transmit clock, 4 general-purpose clock input, 5 crystal oscillator, 6 USB PLL, 7 audio PLL, 8 main PLL, 9 output of divider A. Divider A accepts codes 0–8. Dividers B–E accept codes 0–5, 7, 8 and 9. The external tick and status inputs use bit index = source code (0–8).
- R6: A write whose source code is not on that divider's list changes nothing in that divider: not its word, and not its count. It sets that divider's error flag. The next accepted write to the same divider clears the flag.
- R7: A divider's status output is high exactly when its disable bit is 0 and the selected source's status is high. For code 9 the selected status is divider A's status output.
- R8: Every accepted write to a divider restarts its count from zero. If an accepted write and a source tick fall in the same cycle, the write wins and that source tick is not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_tick | input | 9 | Tick pulse of each external source, indexed by source code |
| ext_on | input | 9 | Running status of each external source, indexed by source code |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | ADDR_W | Byte address of the write |
| wr_data | input | 32 | Write data |
| rd_addr | input | ADDR_W | Byte address of the read |
| rd_data | output | 32 | Read data, combinational from rd_addr |
| div_tick | output | 5 | Output tick of each divider, bit n = divider n |
| div_on | output | 5 | Running status of each divider |
| err_flag | output | 5 | Rejected-write flag of each divider |

## Verification
The two functions that can land in the same cycle are a control-word write, which restarts the count, and a source tick that would complete or advance the count. The bench holds a divider with divide value 0 on a continuous tick stream and issues an accepted rewrite of its unchanged word in the middle of the stream. It then expects exactly one output tick fewer than the number of source ticks. A second case overlaps a rejected write with a partial count, and the bench expects the count to carry on as if no write had happened.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
   localparam int unsigned SEL_W    = 5;
   localparam int unsigned SEL_LSB  = 24;
   localparam int unsigned DIV_LSB  = 2;
   localparam int unsigned NUM_EXT  = 9;
   localparam int unsigned NUM_DIV  = 5;
   localparam int unsigned SRC_DIVA = 9;
   localparam int unsigned SRC_USB  = 6;
   localparam int unsigned NUM_SRC  = NUM_EXT + 1;
   localparam int unsigned SRC_IX_W = $clog2(NUM_SRC);
   localparam logic [SEL_W-1:0] RST_SEL = 5'd1;

   // divider 0 takes any external source; the others drop the USB PLL and add divider 0
   function automatic logic code_ok(input int unsigned idx, input logic [SEL_W-1:0] code);
      if (idx == 0) return code < SEL_W'(NUM_EXT);
      return (code <= SEL_W'(SRC_DIVA)) && (code != SEL_W'(SRC_USB));
   endfunction
endpackage

// File: rtl/clkdiv_cfg.sv
module clkdiv_cfg
   import clkdiv_pkg::*;
#(
   parameter int unsigned IDX    = 0,
   parameter int unsigned DIV_W  = 2,
   parameter int unsigned ADDR_W = 8,
   parameter int unsigned ADDR   = 'h48
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [31:0]       wr_data,
   output logic              dis_o,
   output logic [DIV_W-1:0]  div_o,
   output logic [SEL_W-1:0]  sel_o,
   output logic              err_o,
   output logic              restart_o,
   output logic [31:0]       word_o
);
   if (DIV_W < 1 || DIV_LSB + DIV_W > SEL_LSB) begin : g_bad_width
      $error("clkdiv_cfg: divide width does not fit below the source field");
   end

   logic             hit;
   logic [SEL_W-1:0] sel_new;
   logic             unused_bits;

   assign hit         = wr_en && (wr_addr == ADDR_W'(ADDR));
   assign sel_new     = wr_data[SEL_LSB +: SEL_W];
   assign restart_o   = hit && code_ok(IDX, sel_new);
   assign unused_bits = ^wr_data;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dis_o <= 1'b1;
         sel_o <= RST_SEL;
         div_o <= '0;
         err_o <= 1'b0;
      end else if (restart_o) begin
         dis_o <= wr_data[0];
         sel_o <= sel_new;
         div_o <= wr_data[DIV_LSB +: DIV_W];
         err_o <= 1'b0;
      end else if (hit) begin
         err_o <= 1'b1;
      end
   end

   always_comb begin
      word_o                     = '0;
      word_o[0]                  = dis_o;
      word_o[DIV_LSB +: DIV_W]   = div_o;
      word_o[SEL_LSB +: SEL_W]   = sel_o;
   end

   // R6: a rejected write leaves the word untouched and raises the flag
   p_reject_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && !restart_o) |=> ($stable(word_o) && err_o));

   // R6: the flag only rises after a write addressed here
   p_err_from_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err_o) |-> $past(hit));
endmodule

// File: rtl/clkdiv_count.sv
module clkdiv_count #(
   parameter int unsigned DIV_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             src_tick,
   input  logic             run,
   input  logic             restart,
   input  logic [DIV_W-1:0] div,
   output logic             tick_o
);
   logic [DIV_W-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt    <= '0;
         tick_o <= 1'b0;
      end else begin
         tick_o <= 1'b0;
         if (restart || !run) begin
            cnt <= '0;
         end else if (src_tick) begin
            if (cnt == div) begin
               cnt    <= '0;
               tick_o <= 1'b1;
            end else begin
               cnt <= cnt + 1'b1;
            end
         end
      end
   end

   // R4: every output tick is caused by a counted source tick
   p_tick_from_src_r4: assert property (@(posedge clk) disable iff (!rst_n)
      tick_o |-> $past(src_tick && run && !restart));

   // R4: the count never runs past the divide value
   p_cnt_in_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= div);

   // R3: a disabled divider is silent next cycle
   p_quiet_when_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> !tick_o);
endmodule

// File: rtl/clkdiv_bank.sv
module clkdiv_bank
   import clkdiv_pkg::*;
#(
   parameter int unsigned ADDR_W    = 8,
   parameter int unsigned BASE_ADDR = 'h48,
   parameter int unsigned WIDTH_A   = 2,
   parameter int unsigned WIDTH_MID = 4,
   parameter int unsigned WIDTH_E   = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_EXT-1:0] ext_tick,
   input  logic [NUM_EXT-1:0] ext_on,
   input  logic               wr_en,
   input  logic [ADDR_W-1:0]  wr_addr,
   input  logic [31:0]        wr_data,
   input  logic [ADDR_W-1:0]  rd_addr,
   output logic [31:0]        rd_data,
   output logic [NUM_DIV-1:0] div_tick,
   output logic [NUM_DIV-1:0] div_on,
   output logic [NUM_DIV-1:0] err_flag
);
   if (BASE_ADDR + 4 * NUM_DIV > (1 << ADDR_W)) begin : g_bad_addr
      $error("clkdiv_bank: register window does not fit the address width");
   end

   logic        a_tick;
   logic        a_on;
   logic [31:0] word_arr [NUM_DIV];

   for (genvar g = 0; g < NUM_DIV; g++) begin : g_div
      localparam int unsigned W = (g == 0) ? WIDTH_A :
                                  (g == NUM_DIV - 1) ? WIDTH_E : WIDTH_MID;
      logic               dis;
      logic [W-1:0]       div;
      logic [SEL_W-1:0]   sel;
      logic               restart;
      logic [NUM_SRC-1:0] tick_vec;
      logic [NUM_SRC-1:0] on_vec;
      logic               src_t;
      logic               on_w;
      logic               tick_w;

      clkdiv_cfg #(
         .IDX(g), .DIV_W(W), .ADDR_W(ADDR_W), .ADDR(BASE_ADDR + 4 * g)
      ) i_cfg (
         .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
         .wr_data(wr_data), .dis_o(dis), .div_o(div), .sel_o(sel),
         .err_o(err_flag[g]), .restart_o(restart), .word_o(word_arr[g])
      );

      if (g == 0) begin : g_first
         assign tick_vec = {1'b0, ext_tick};
         assign on_vec   = {1'b0, ext_on};
         assign a_tick   = tick_w;
         assign a_on     = on_w;
      end else begin : g_rest
         assign tick_vec = {a_tick, ext_tick};
         assign on_vec   = {a_on, ext_on};
      end

      assign src_t = (sel < SEL_W'(NUM_SRC)) ? tick_vec[sel[SRC_IX_W-1:0]] : 1'b0;
      assign on_w  = !dis && (sel < SEL_W'(NUM_SRC)) && on_vec[sel[SRC_IX_W-1:0]];
      assign div_on[g]   = on_w;
      assign div_tick[g] = tick_w;

      clkdiv_count #(.DIV_W(W)) i_count (
         .clk(clk), .rst_n(rst_n), .src_tick(src_t), .run(!dis),
         .restart(restart), .div(div), .tick_o(tick_w)
      );

      // R7: a divider never reports running while its gate bit is set
      p_on_needs_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
         div_on[g] |-> (word_arr[g][0] == 1'b0));
   end

   always_comb begin
      rd_data = '0;
      for (int i = 0; i < NUM_DIV; i++) begin
         if (rd_addr == ADDR_W'(BASE_ADDR + 4 * i)) rd_data = word_arr[i];
      end
   end
endmodule

// File: tb/test_clkdiv_bank.sv
`timescale 1ns/1ps
module test_clkdiv_bank;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [8:0]  ext_tick = '0;
   logic [8:0]  ext_on = '0;
   logic        wr_en = 1'b0;
   logic [7:0]  wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic [7:0]  rd_addr = '0;
   logic [31:0] rd_data;
   logic [4:0]  div_tick, div_on, err_flag;

   int total = 0;
   int bad = 0;
   bit done = 0;
   int tcount [5];

   always #2 clk = ~clk;

   clkdiv_bank i_clkdiv_bank (
      .clk(clk), .rst_n(rst_n), .ext_tick(ext_tick), .ext_on(ext_on),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
      .rd_data(rd_data), .div_tick(div_tick), .div_on(div_on), .err_flag(err_flag)
   );

   always @(negedge clk) begin
      for (int i = 0; i < 5; i++) if (div_tick[i]) tcount[i]++;
   end

   typedef struct packed {
      logic [2:0]  idx;
      logic [31:0] data;
      logic [31:0] rd;
      logic        err;
   } vec_t;

   // walked in order: each entry sees the state the previous ones left (R2 R4 R6)
   localparam vec_t VECS [9] = '{
      '{3'd0, 32'h0500_0005, 32'h0500_0005, 1'b0},
      '{3'd0, 32'h0900_0000, 32'h0500_0005, 1'b1},
      '{3'd0, 32'h08FF_FFFC, 32'h0800_000C, 1'b0},
      '{3'd1, 32'h0600_0010, 32'h0100_0001, 1'b1},
      '{3'd1, 32'h0900_03FC, 32'h0900_003C, 1'b0},
      '{3'd4, 32'h0700_0321, 32'h0700_0321, 1'b0},
      '{3'd4, 32'h1F00_0000, 32'h0700_0321, 1'b1},
      '{3'd2, 32'h0000_0002, 32'h0000_0000, 1'b0},
      '{3'd3, 32'h0A00_0000, 32'h0100_0001, 1'b1}
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] addr, input logic [31:0] data);
      wr_addr = addr; wr_data = data; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic wr_div(input int idx, input logic [31:0] data);
      wr(8'(8'h48 + 4 * idx), data);
   endtask

   task automatic rd_div(input int idx, output logic [31:0] v);
      rd_addr = 8'(8'h48 + 4 * idx);
      #1 v = rd_data;
   endtask

   task automatic feed(input int src, input int k);
      ext_tick[src] = 1'b1;
      repeat (k) @(negedge clk);
      ext_tick[src] = 1'b0;
      repeat (4) @(negedge clk);
   endtask

   task automatic clr_counts();
      for (int i = 0; i < 5; i++) tcount[i] = 0;
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      finish_run();
   end

   initial begin
      logic [31:0] v;
      @(negedge clk);
      do_reset();

      // table walk
      foreach (VECS[i]) begin
         wr_div(int'(VECS[i].idx), VECS[i].data);
         rd_div(int'(VECS[i].idx), v);
         chk("R2/R4/R6 readback", v, VECS[i].rd);
         chk("R6 error flag", 32'(err_flag[VECS[i].idx]), 32'(VECS[i].err));
      end

      // R1 reset state
      do_reset();
      ext_on = '1;
      for (int i = 0; i < 5; i++) begin
         rd_div(i, v);
         chk("R1 reset word", v, 32'h0100_0001);
      end
      #1;
      chk("R1 error flags", 32'(err_flag), 32'h0);
      chk("R1 status low", 32'(div_on), 32'h0);
      clr_counts();
      feed(1, 5);
      chk("R1/R3 no ticks after reset", 32'(tcount[0] + tcount[1] + tcount[2] + tcount[3] + tcount[4]), 32'd0);

      // R2 writes elsewhere do nothing
      wr(8'h44, 32'h0500_0000);
      wr(8'h5C, 32'h0500_0000);
      for (int i = 0; i < 5; i++) begin
         rd_div(i, v);
         chk("R2 stray write ignored", v, 32'h0100_0001);
      end
      rd_addr = 8'h44; #1;
      chk("R2 empty address reads zero", rd_data, 32'h0);

      // R4 divide ratios
      wr_div(0, 32'h0500_0008);
      wr_div(4, 32'h0500_0024);
      clr_counts();
      feed(5, 30);
      chk("R4 divider A by 3", 32'(tcount[0]), 32'd10);
      chk("R4 divider E by 10", 32'(tcount[4]), 32'd3);
      wr_div(2, 32'h0100_0000);
      clr_counts();
      feed(1, 7);
      chk("R4 divide value 0 passes ticks", 32'(tcount[2]), 32'd7);

      // R5 source selection
      wr_div(3, 32'h0800_0004);
      clr_counts();
      feed(5, 6);
      chk("R5 unselected source ignored", 32'(tcount[3]), 32'd0);
      feed(8, 6);
      chk("R5 main PLL code 8", 32'(tcount[3]), 32'd3);

      // R5 chain: B takes A (code 9)
      wr_div(1, 32'h0900_0004);
      clr_counts();
      feed(5, 12);
      chk("R5 chain source A", 32'(tcount[0]), 32'd4);
      chk("R5 chain divider B", 32'(tcount[1]), 32'd2);

      // R7 status follows the chain
      #1;
      chk("R7 A and B running", 32'(div_on[1:0]), 32'h3);
      ext_on[5] = 1'b0; #1;
      chk("R7 source stop clears chain", 32'(div_on[1:0]), 32'h0);
      ext_on[5] = 1'b1;
      @(negedge clk);
      wr_div(0, 32'h0500_0009);
      #1;
      chk("R7 disabled A clears B", 32'(div_on[1:0]), 32'h0);
      chk("R7 C on RC running", 32'(div_on[2]), 32'h1);
      ext_on[1] = 1'b0; #1;
      chk("R7 C source stopped", 32'(div_on[2]), 32'h0);
      ext_on[1] = 1'b1;
      @(negedge clk);

      // R3 disable bit
      wr_div(2, 32'h0100_0001);
      clr_counts();
      feed(1, 5);
      chk("R3 disabled divider silent", 32'(tcount[2]), 32'd0);

      // R8 restart on accepted write
      wr_div(2, 32'h0500_000C);
      clr_counts();
      feed(5, 2);
      wr_div(2, 32'h0500_000C);
      feed(5, 2);
      chk("R8 rewrite restarts count", 32'(tcount[2]), 32'd0);
      feed(5, 2);
      chk("R8 count completes after restart", 32'(tcount[2]), 32'd1);

      // R8 write and source tick in one cycle
      wr_div(3, 32'h0500_0000);
      clr_counts();
      ext_tick[5] = 1'b1;
      repeat (2) @(negedge clk);
      wr_div(3, 32'h0500_0000);
      repeat (3) @(negedge clk);
      ext_tick[5] = 1'b0;
      repeat (4) @(negedge clk);
      chk("R8 write beats same-cycle tick", 32'(tcount[3]), 32'd5);

      // R6 rejected write keeps the count going
      wr_div(2, 32'h0500_000C);
      clr_counts();
      feed(5, 2);
      wr_div(2, 32'h0600_000C);
      chk("R6 rejected write flags C", 32'(err_flag[2]), 32'h1);
      feed(5, 2);
      chk("R6 rejected write keeps count", 32'(tcount[2]), 32'd1);
      rd_div(2, v);
      chk("R6 rejected write keeps word", v, 32'h0500_000C);

      finish_run();
   end
endmodule